// File: doc/BRIEF.md
# Piecewise Nonlinear Error Gain Stage

This block scales a signed error sample by one of several programmable gains before the sample enters a downstream compensation filter. The gain depends on where the error lies relative to a set of programmable signed thresholds. A control loop can therefore respond with one gain near zero error and with other gains, often stronger, as the error grows in either direction. The thresholds need not be symmetric about zero, and they need not be ordered.

Each accepted sample is multiplied by an unsigned gain code with 8 fractional bits, so a code of 256 means 1.0. The lowest `DROP_W` bits of the product (default 1) are removed with rounding, and the result is clamped to a signed `OUT_W`-bit value. The scaled result and its strobe come out of a register one clock after the input strobe.

Top module: `nlgain_stage`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted sample, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. `out_data` for that sample appears in the same cycle.
- R3: Limit k occupies `lim_cfg[k*ERR_W +: ERR_W]` and gain j occupies `gain_cfg[j*GAIN_W +: GAIN_W]`. With ascending limits, an error below limit 0 uses gain 0, an error at or above limit k-1 and below limit k uses gain k, and an error at or above the last limit uses the last gain.
- R4: An error exactly equal to a limit uses the gain of the region above that limit.
- R5: The gain index is one more than the highest limit index k whose limit is at or below the error, or 0 if no limit is at or below it. This rule also holds when the limits are not in ascending order.
- R6: If every limit is positive, every negative error uses gain 0.
- R7: `out_data` equals floor((error × gain + 2^(DROP_W−1)) / 2^DROP_W). With the default of 1 this rounds halves toward plus infinity: error 1 with gain 3 gives 2, and error −1 with gain 3 gives −1.
- R8: A rounded result above 2^(OUT_W−1)−1 gives exactly 2^(OUT_W−1)−1 (32767 by default).
- R9: A rounded result below −2^(OUT_W−1) gives exactly −2^(OUT_W−1) (−32768 by default).
- R10: In cycles after `in_valid` was low, `out_data` holds its last value, whatever `in_err` or the configuration inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking a new error sample |
| in_err | input | ERR_W | Error sample, two's complement |
| lim_cfg | input | N_LIM*ERR_W | Signed threshold registers, limit k at bits [k*ERR_W +: ERR_W] |
| gain_cfg | input | (N_LIM+1)*GAIN_W | Unsigned gain codes with 8 fractional bits, gain j at bits [j*GAIN_W +: GAIN_W] |
| out_valid | output | 1 | Strobe for the scaled result |
| out_data | output | OUT_W | Scaled, rounded, clamped error, two's complement |

## Verification
The case that is hardest to reach from the ports is a set of limits that are out of order. There, several comparisons against limits are true together and the priority rule alone decides the gain. The bench reprograms the limit registers to such a set. It then chooses errors for which a count of true comparisons and the highest-index rule give different regions, and it gives every region a distinct gain so that the output shows which region was used. The bench reaches the clamp boundaries by setting all gains to the largest code. It then drives errors just inside and just outside the representable range.

// File: rtl/npg_pkg.sv
package npg_pkg;

   localparam int DEF_ERR_W  = 6;
   localparam int DEF_GAIN_W = 12;
   localparam int DEF_N_LIM  = 4;
   localparam int DEF_OUT_W  = 16;
   localparam int DEF_DROP_W = 1;

   // width of a region index that can address n_lim+1 regions
   function automatic int sel_w(input int n_lim);
      return (n_lim < 1) ? 1 : $clog2(n_lim + 1);
   endfunction

endpackage

// File: rtl/npg_region_sel.sv
module npg_region_sel #(
   parameter int ERR_W = npg_pkg::DEF_ERR_W,
   parameter int N_LIM = npg_pkg::DEF_N_LIM,
   localparam int SEL_W = npg_pkg::sel_w(N_LIM)
) (
   input  logic signed [ERR_W-1:0]       err_i,
   input  logic        [N_LIM*ERR_W-1:0] lim_i,
   output logic        [SEL_W-1:0]       sel_o
);

   logic [N_LIM-1:0] at_or_above;

   for (genvar k = 0; k < N_LIM; k++) begin : g_cmp
      assign at_or_above[k] = (err_i >= $signed(lim_i[k*ERR_W +: ERR_W]));
   end

   // highest-index true comparison wins
   always_comb begin
      sel_o = '0;
      for (int k = 0; k < N_LIM; k++) begin
         if (at_or_above[k]) sel_o = SEL_W'(k + 1);
      end
   end

endmodule

// File: rtl/npg_gain_pick.sv
module npg_gain_pick #(
   parameter int GAIN_W = npg_pkg::DEF_GAIN_W,
   parameter int N_LIM  = npg_pkg::DEF_N_LIM,
   localparam int N_REG = N_LIM + 1,
   localparam int SEL_W = npg_pkg::sel_w(N_LIM)
) (
   input  logic [SEL_W-1:0]        sel_i,
   input  logic [N_REG*GAIN_W-1:0] gains_i,
   output logic [GAIN_W-1:0]       gain_o
);

   always_comb begin
      gain_o = '0;
      for (int k = 0; k < N_REG; k++) begin
         if (sel_i == SEL_W'(k)) gain_o = gains_i[k*GAIN_W +: GAIN_W];
      end
   end

endmodule

// File: rtl/npg_scale_sat.sv
module npg_scale_sat #(
   parameter int ERR_W  = npg_pkg::DEF_ERR_W,
   parameter int GAIN_W = npg_pkg::DEF_GAIN_W,
   parameter int OUT_W  = npg_pkg::DEF_OUT_W,
   parameter int DROP_W = npg_pkg::DEF_DROP_W
) (
   input  logic signed [ERR_W-1:0]  err_i,
   input  logic        [GAIN_W-1:0] gain_i,
   output logic signed [OUT_W-1:0]  val_o
);

   localparam int PROD_W = ERR_W + GAIN_W + 1;
   localparam int SUM_W  = PROD_W + 1;

   logic signed [PROD_W-1:0] err_x;
   logic signed [PROD_W-1:0] gain_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [SUM_W-1:0]  scaled;

   assign err_x  = {{(GAIN_W+1){err_i[ERR_W-1]}}, err_i};
   assign gain_x = {{(ERR_W+1){1'b0}}, gain_i};
   assign prod   = err_x * gain_x;

   if (DROP_W > 0) begin : g_round
      localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (DROP_W - 1);
      logic signed [SUM_W-1:0] biased;
      assign biased = {prod[PROD_W-1], prod} + HALF;
      assign scaled = biased >>> DROP_W;
   end else begin : g_exact
      assign scaled = {prod[PROD_W-1], prod};
   end

   if (SUM_W > OUT_W) begin : g_clamp
      localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
      localparam logic signed [SUM_W-1:0] MINV = ~MAXV;
      always_comb begin
         if (scaled > MAXV)      val_o = MAXV[OUT_W-1:0];
         else if (scaled < MINV) val_o = MINV[OUT_W-1:0];
         else                    val_o = scaled[OUT_W-1:0];
      end
   end else begin : g_widen
      assign val_o = OUT_W'(scaled);
   end

endmodule

// File: rtl/nlgain_stage.sv
module nlgain_stage #(
   parameter int ERR_W  = npg_pkg::DEF_ERR_W,
   parameter int GAIN_W = npg_pkg::DEF_GAIN_W,
   parameter int N_LIM  = npg_pkg::DEF_N_LIM,
   parameter int OUT_W  = npg_pkg::DEF_OUT_W,
   parameter int DROP_W = npg_pkg::DEF_DROP_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [ERR_W-1:0]              in_err,
   input  logic [N_LIM*ERR_W-1:0]        lim_cfg,
   input  logic [(N_LIM+1)*GAIN_W-1:0]   gain_cfg,
   output logic                          out_valid,
   output logic [OUT_W-1:0]              out_data
);

   localparam int SEL_W  = npg_pkg::sel_w(N_LIM);
   localparam int PROD_W = ERR_W + GAIN_W + 1;

   if (ERR_W < 2)                      begin : g_bad_err  $error("ERR_W must be at least 2");        end
   if (GAIN_W < 1)                     begin : g_bad_gain $error("GAIN_W must be at least 1");       end
   if (N_LIM < 1)                      begin : g_bad_lim  $error("N_LIM must be at least 1");        end
   if (OUT_W < 2 || OUT_W > 31)        begin : g_bad_out  $error("OUT_W must lie in 2..31");         end
   if (DROP_W < 0 || DROP_W >= PROD_W) begin : g_bad_drop $error("DROP_W out of range");             end

   logic [SEL_W-1:0]        region;
   logic [GAIN_W-1:0]       gain_sel;
   logic signed [OUT_W-1:0] result;

   npg_region_sel #(.ERR_W(ERR_W), .N_LIM(N_LIM)) u_sel (
      .err_i (in_err),
      .lim_i (lim_cfg),
      .sel_o (region)
   );

   npg_gain_pick #(.GAIN_W(GAIN_W), .N_LIM(N_LIM)) u_pick (
      .sel_i   (region),
      .gains_i (gain_cfg),
      .gain_o  (gain_sel)
   );

   npg_scale_sat #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .DROP_W(DROP_W)) u_scale (
      .err_i  (in_err),
      .gain_i (gain_sel),
      .val_o  (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end

endmodule

// File: rtl/nlgain_stage_chk.sv
module nlgain_stage_chk #(
   parameter int ERR_W = npg_pkg::DEF_ERR_W,
   parameter int OUT_W = npg_pkg::DEF_OUT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [ERR_W-1:0] in_err,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data
);

   a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   a_r7_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_err == '0) |=> (out_data == '0));

   a_r8_positive_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $signed(in_err) > 0) |=> ($signed(out_data) >= 0));

   a_r9_negative_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $signed(in_err) < 0) |=> ($signed(out_data) <= 0));

endmodule

bind nlgain_stage nlgain_stage_chk #(.ERR_W(ERR_W), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_err    (in_err),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/nlgain_stage_tb_top.sv
module nlgain_stage_tb_top;

   localparam int ERR_W  = 6;
   localparam int GAIN_W = 12;
   localparam int N_LIM  = 4;
   localparam int OUT_W  = 16;
   localparam int DROP_W = 1;

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic                        in_valid = 1'b0;
   logic [ERR_W-1:0]            in_err = '0;
   logic [N_LIM*ERR_W-1:0]      lim_cfg = '0;
   logic [(N_LIM+1)*GAIN_W-1:0] gain_cfg = '0;
   logic                        out_valid;
   logic [OUT_W-1:0]            out_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int lim_m  [N_LIM];
   int gain_m [N_LIM+1];

   always #2 clk = ~clk;

   nlgain_stage #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .N_LIM(N_LIM),
                  .OUT_W(OUT_W), .DROP_W(DROP_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_err(in_err),
      .lim_cfg(lim_cfg), .gain_cfg(gain_cfg),
      .out_valid(out_valid), .out_data(out_data));

   // table: error value and the region it must land in (limits -8,-2,3,10)
   typedef struct packed { logic signed [7:0] err; logic [3:0] region; } vec_t;
   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{-8'sd32, 4'd0}, '{-8'sd9, 4'd0}, '{-8'sd8, 4'd1}, '{-8'sd3, 4'd1},
      '{-8'sd2,  4'd2}, '{8'sd0,  4'd2}, '{8'sd2,  4'd2}, '{8'sd3,  4'd3},
      '{8'sd9,   4'd3}, '{8'sd10, 4'd4}, '{8'sd31, 4'd4}};

   function automatic int scale_ref(input int e, input int g);
      int p;
      int r;
      p = e * g;
      r = (p + (1 <<< (DROP_W - 1))) >>> DROP_W;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   function automatic int region_ref(input int e);
      int s;
      s = 0;
      for (int k = 0; k < N_LIM; k++) if (e >= lim_m[k]) s = k + 1;
      return s;
   endfunction

   task automatic load_cfg();
      for (int k = 0; k < N_LIM; k++) lim_cfg[k*ERR_W +: ERR_W] = ERR_W'(lim_m[k]);
      for (int k = 0; k <= N_LIM; k++) gain_cfg[k*GAIN_W +: GAIN_W] = GAIN_W'(gain_m[k]);
   endtask

   task automatic step(input bit v, input int e);
      @(negedge clk);
      in_valid = v;
      in_err   = ERR_W'(e);
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 data in reset", $signed(out_data), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 5);
      check("R1 valid after release", int'(out_valid), 0);
      check("R1 data after release", $signed(out_data), 0);

      // R3/R4 table: ascending limits, distinct gains
      lim_m  = '{-8, -2, 3, 10};
      gain_m = '{768, 384, 256, 192, 1024};
      load_cfg();
      foreach (VECS[i]) begin
         int e;
         int exp;
         e = int'(VECS[i].err);
         exp = scale_ref(e, gain_m[VECS[i].region]);
         step(1, e);
         check("R3 R4 region table", $signed(out_data), exp);
         check("R2 strobe", int'(out_valid), 1);
      end

      // R2 / R10: idle cycles keep data and drop strobe
      step(1, 7);
      step(0, -20);
      check("R2 strobe low", int'(out_valid), 0);
      check("R10 hold", $signed(out_data), scale_ref(7, 192));
      gain_m = '{1, 1, 1, 1, 1};
      load_cfg();
      step(0, 25);
      check("R10 hold cfg change", $signed(out_data), scale_ref(7, 192));

      // R5: out-of-order limits, count rule and priority rule disagree
      lim_m  = '{5, -10, 20, 25};
      gain_m = '{16, 32, 48, 64, 80};
      load_cfg();
      step(1, 1);
      check("R5 unordered limits", $signed(out_data), 24);
      step(1, 22);
      check("R5 unordered high", $signed(out_data), scale_ref(22, gain_m[region_ref(22)]));
      check("R5 model region", region_ref(22), 3);

      // R6: all limits positive
      lim_m  = '{1, 4, 8, 16};
      gain_m = '{256, 512, 1024, 2048, 4095};
      load_cfg();
      step(1, -1);
      check("R6 negative uses gain0", $signed(out_data), -128);
      step(1, -32);
      check("R6 most negative", $signed(out_data), -4096);

      // R7: rounding with equal gains
      lim_m  = '{-8, -2, 3, 10};
      gain_m = '{3, 3, 3, 3, 3};
      load_cfg();
      step(1, 1);
      check("R7 +1.5 rounds up", $signed(out_data), 2);
      step(1, -1);
      check("R7 -1.5 rounds up", $signed(out_data), -1);
      gain_m = '{1, 1, 1, 1, 1};
      load_cfg();
      step(1, -1);
      check("R7 -0.5 rounds to 0", $signed(out_data), 0);
      step(1, 1);
      check("R7 +0.5 rounds to 1", $signed(out_data), 1);

      // R8 / R9: clamp edges
      gain_m = '{4095, 4095, 4095, 4095, 4095};
      load_cfg();
      step(1, 16);
      check("R8 just inside", $signed(out_data), 32760);
      step(1, 17);
      check("R8 positive clamp", $signed(out_data), 32767);
      step(1, 31);
      check("R8 max error", $signed(out_data), 32767);
      step(1, -16);
      check("R9 just inside", $signed(out_data), -32760);
      step(1, -32);
      check("R9 negative clamp", $signed(out_data), -32768);

      // R1: reset mid-stream clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async clear valid", int'(out_valid), 0);
      check("R1 async clear data", $signed(out_data), 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule